// File: doc/BRIEF.md
# Periodic Interval Timer

This block produces the periodic tick that an operating-system scheduler runs on. A divider derived from the system clock advances a 20-bit period counter once every sixteen clocks. When the counter reaches the programmed limit it returns to zero and raises a pending flag. A 12-bit tally counts the wraps since software last acknowledged them, so software can tell how many ticks it has missed.

Software reaches the block through a small single-cycle register port with four word addresses. One register holds the configuration. One reports the pending flag. Two return the same combined tally-and-count value: reading one of them acknowledges, reading the other does not. The interrupt output is the pending flag gated by an interrupt-enable bit, and it goes to an external interrupt controller.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `irq` is low.
- R2: While the counter runs, its value advances by one every 16 clock cycles (parameter PRESCALE). The first step lands on the 16th rising edge after the edge that wrote the run enable. The value does not change between steps.
- R3: The configuration word (address 0) holds the limit in bits [19:0]. The counter counts 0, 1, ... up to the limit, so the period is limit+1 steps, any value from 1 to 2^20. A step taken when the value is at or above the limit wraps it.
- R4: On a wrap the counter becomes 0, the pending flag is set and the tally increments.
- R5: The 12-bit tally rolls over from 4095 to 0 without any other effect.
- R6: Bit 30 of the configuration word is the run enable. With it clear, the counter keeps stepping while its value is nonzero and holds once it reaches 0. The divider restarts from zero when running resumes.
- R7: A read of address 2 returns the tally in bits [31:20] and the count in bits [19:0], and clears both the flag and the tally. If a wrap falls in the same cycle, the flag is left set and the tally becomes 1.
- R8: A read of address 3 returns the same layout as address 2 and changes nothing.
- R9: Bit 31 of the configuration word is the interrupt enable. `irq` equals the pending flag AND the enable, and it stays high until an acknowledging read. Address 1 bit 0 reads the pending flag regardless of the enable.
- R10: Address 0 reads back the limit, run enable and interrupt enable as last written, with the other bits zero. Writes to addresses 1 to 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Word address: 0 config, 1 status, 2 value with acknowledge, 3 value image |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the access, zero otherwise |
| irq | output | 1 | Tick interrupt request |

## Verification
A fault in the divider or the period counter appears at the image register within one step, as a count off by one or late by a clock. A wrap that is missed or taken early moves the rise of `irq` and the tally by a whole period. A fault in the tally or in the acknowledge logic shows on the next value read, either as a tally that survives acknowledgement or one that is lost. The rollover from 4095 and the stop-at-zero behaviour are each checked by reading the image register just before and just after the point where they occur.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   typedef enum logic [1:0] {
      REG_CFG      = 2'd0,
      REG_STATUS   = 2'd1,
      REG_SNAP_ACK = 2'd2,
      REG_SNAP     = 2'd3
   } reg_addr_e;

   localparam int DATA_W = 32;
   localparam int RUN_BIT = 30;
   localparam int IEN_BIT = 31;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int PRESCALE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   generate
      if (PRESCALE == 1) begin : g_direct
         logic pre_unused;
         assign pre_unused = clk ^ rst_n;
         assign tick = run;
      end else begin : g_divide
         logic [PRE_W-1:0] phase_q;
         logic             last_phase;

         assign last_phase = (phase_q == PRE_W'(PRESCALE - 1));
         assign tick       = run && last_phase;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (!run || last_phase) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end

         // R2: steps are never back to back when dividing
         p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);

         // R6: a stopped divider restarts from its first phase
         p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/tick_period_counter.sv
module tick_period_counter #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);

   logic [CNT_W-1:0] count_q;

   assign wrap  = tick && (count_q >= limit);
   assign count = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (tick) begin
         count_q <= wrap ? '0 : count_q + 1'b1;
      end
   end

   // R3: a step below the limit adds exactly one
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wrap) |=> (count == $past(count) + CNT_W'(1)));

   // R4: a wrap always lands on zero
   p_zero_after_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (count == '0));

   // R2: no change between steps
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));

endmodule

// File: rtl/tick_wrap_tally.sv
module tick_wrap_tally #(
   parameter int TALLY_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wrap,
   input  logic               ack,
   output logic [TALLY_W-1:0] tally,
   output logic               pending
);

   logic [TALLY_W-1:0] tally_q;
   logic               pending_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tally_q   <= '0;
         pending_q <= 1'b0;
      end else if (ack) begin
         tally_q   <= wrap ? TALLY_W'(1) : '0;
         pending_q <= wrap;
      end else if (wrap) begin
         tally_q   <= tally_q + 1'b1;
         pending_q <= 1'b1;
      end
   end

   assign tally   = tally_q;
   assign pending = pending_q;

   // R5: the tally steps by one per wrap, rolling over silently
   p_tally_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !ack) |=> (tally == $past(tally) + TALLY_W'(1)));

   // R7: an acknowledge without a wrap empties both
   p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !wrap) |=> (tally == '0 && !pending));

   // R9: the flag holds until acknowledged
   p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !ack) |=> pending);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int PRESCALE = 16,
   parameter int CNT_W    = 20,
   parameter int TALLY_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);

   if (PRESCALE < 1) begin : g_bad_prescale
      $error("tick_timer: PRESCALE must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > RUN_BIT - 1) begin : g_bad_cnt_w
      $error("tick_timer: CNT_W must lie in 1..29");
   end
   if (TALLY_W < 1 || CNT_W + TALLY_W > DATA_W) begin : g_bad_tally_w
      $error("tick_timer: CNT_W + TALLY_W must fit the data word");
   end

   logic [CNT_W-1:0]   limit_q;
   logic               run_en_q;
   logic               irq_en_q;
   logic               cfg_write;
   logic               ack_read;
   logic               running;
   logic               tick;
   logic               wrap;
   logic [CNT_W-1:0]   count;
   logic [TALLY_W-1:0] tally;
   logic               pending;
   logic               cfg_unused;

   assign cfg_write  = reg_sel && reg_wr && (reg_addr == REG_CFG);
   assign ack_read   = reg_sel && !reg_wr && (reg_addr == REG_SNAP_ACK);
   assign cfg_unused = ^reg_wdata[RUN_BIT-1:CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q  <= '0;
         run_en_q <= 1'b0;
         irq_en_q <= 1'b0;
      end else if (cfg_write) begin
         limit_q  <= reg_wdata[CNT_W-1:0];
         run_en_q <= reg_wdata[RUN_BIT];
         irq_en_q <= reg_wdata[IEN_BIT];
      end
   end

   // a cleared enable lets the current period finish at zero
   assign running = run_en_q || (count != '0);

   tick_prescaler #(.PRESCALE(PRESCALE)) u_prescaler (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (running),
      .tick  (tick)
   );

   tick_period_counter #(.CNT_W(CNT_W)) u_period (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .limit (limit_q),
      .count (count),
      .wrap  (wrap)
   );

   tick_wrap_tally #(.TALLY_W(TALLY_W)) u_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap    (wrap),
      .ack     (ack_read),
      .tally   (tally),
      .pending (pending)
   );

   logic [DATA_W-1:0] cfg_word;
   logic [DATA_W-1:0] snap_word;

   always_comb begin
      cfg_word                = '0;
      cfg_word[CNT_W-1:0]     = limit_q;
      cfg_word[RUN_BIT]       = run_en_q;
      cfg_word[IEN_BIT]       = irq_en_q;
      snap_word               = '0;
      snap_word[CNT_W-1:0]    = count;
      snap_word[DATA_W-1 -: TALLY_W] = tally;
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_sel && !reg_wr) begin
         unique case (reg_addr)
            REG_CFG:      reg_rdata = cfg_word;
            REG_STATUS:   reg_rdata = {{(DATA_W-1){1'b0}}, pending};
            REG_SNAP_ACK: reg_rdata = snap_word;
            REG_SNAP:     reg_rdata = snap_word;
            default:      reg_rdata = '0;
         endcase
      end
   end

   assign irq = pending && irq_en_q;

   // R9: the request stays up until acknowledged or its enable is rewritten
   p_irq_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack_read && !cfg_write) |=> irq);

   // R6: stopped at zero means it stays at zero
   p_stop_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en_q && count == '0 && !cfg_write) |=> (count == '0));

   // R4: a wrap raises the flag on the next cycle
   p_wrap_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> pending);

endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

   localparam int PRE = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic        irq;

   always #10 clk = ~clk;

   tick_timer u_tick_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   // ---------------- reference model from the requirements ----------------
   int m_pre, m_cnt, m_lim, m_tal;
   bit m_en, m_ie, m_flag;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pre = 0; m_cnt = 0; m_lim = 0; m_tal = 0;
         m_en = 0; m_ie = 0; m_flag = 0;
      end else begin
         bit run, step, wrp, ack;
         run  = m_en || (m_cnt != 0);
         step = run && (m_pre == PRE - 1);
         if (!run || m_pre == PRE - 1) m_pre = 0;
         else m_pre = m_pre + 1;
         wrp = step && (m_cnt >= m_lim);
         if (step) m_cnt = wrp ? 0 : m_cnt + 1;
         ack = reg_sel && !reg_wr && reg_addr == 2'd2;
         if (ack) begin
            m_tal  = wrp ? 1 : 0;
            m_flag = wrp;
         end else if (wrp) begin
            m_tal  = (m_tal + 1) % 4096;
            m_flag = 1;
         end
         if (reg_sel && reg_wr && reg_addr == 2'd0) begin
            m_lim = int'(reg_wdata[19:0]);
            m_en  = reg_wdata[30];
            m_ie  = reg_wdata[31];
         end
      end
   end

   function automatic logic [31:0] model_read(input logic [1:0] a);
      case (a)
         2'd0:    return {m_ie, m_en, 10'd0, 20'(m_lim)};
         2'd1:    return {31'd0, m_flag};
         default: return {12'(m_tal), 20'(m_cnt)};
      endcase
   endfunction

   // ---------------- scoreboard ----------------
   typedef struct {
      bit          is_irq;
      string       tag;
      logic [31:0] exp;
   } item_t;

   item_t q[$];
   item_t it;
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 0;

   always @(negedge clk) begin
      while (q.size() > 0) begin
         logic [31:0] act;
         it  = q.pop_front();
         act = it.is_irq ? {31'd0, irq} : reg_rdata;
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   // ---------------- driver ----------------
   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic rd(input logic [1:0] a, input string tag);
      item_t e;
      reg_sel  = 1'b1;
      reg_wr   = 1'b0;
      reg_addr = a;
      e.is_irq = 1'b0;
      e.tag    = tag;
      e.exp    = model_read(a);
      q.push_back(e);
      idle(1);
      reg_sel = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_sel   = 1'b1;
      reg_wr    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      idle(1);
      reg_sel = 1'b0;
      reg_wr  = 1'b0;
   endtask

   task automatic chk_irq(input string tag, input bit exp);
      item_t e;
      e.is_irq = 1'b1;
      e.tag    = tag;
      e.exp    = {31'd0, exp};
      q.push_back(e);
   endtask

   function automatic logic [31:0] cfg(input bit ie, input bit en, input int lim);
      return {ie, en, 10'd0, 20'(lim)};
   endfunction

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1: reset state
      rd(2'd0, "R1 config after reset");
      rd(2'd1, "R1 status after reset");
      rd(2'd3, "R1 value after reset");
      chk_irq("R1 irq after reset", 1'b0);
      idle(1);

      // R2: first step on the 16th edge after enabling
      wr(2'd0, cfg(1, 1, 3));
      idle(14);
      rd(2'd3, "R2 count before first step");
      rd(2'd3, "R2 count at first step");
      idle(20);
      rd(2'd3, "R2 count after two steps");

      // R4, R9: wrap at limit 3 raises the flag and irq
      idle(40);
      rd(2'd3, "R4 value after first wrap");
      chk_irq("R9 irq after wrap", 1'b1);
      rd(2'd1, "R9 status flag set");

      // R8: image reads leave everything in place
      rd(2'd3, "R8 image read one");
      rd(2'd3, "R8 image read two");
      chk_irq("R8 irq kept by image read", 1'b1);

      // R7: acknowledging read clears flag and tally
      rd(2'd2, "R7 acknowledging read value");
      chk_irq("R7 irq dropped after acknowledge", 1'b0);
      rd(2'd3, "R7 tally cleared");
      rd(2'd1, "R7 flag cleared");

      // R9: flag without interrupt enable
      wr(2'd0, cfg(0, 1, 3));
      rd(2'd0, "R10 config readback");
      idle(70);
      chk_irq("R9 irq masked", 1'b0);
      rd(2'd1, "R9 status shows flag while masked");
      wr(2'd0, cfg(1, 1, 3));
      chk_irq("R9 irq appears when enabled", 1'b1);
      rd(2'd2, "R7 acknowledge before exceed test");

      // R10: writes to other addresses are ignored
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd0, "R10 config untouched by other writes");

      // R3: lowering the limit below the count wraps on the next step
      wr(2'd0, cfg(1, 1, 50));
      idle(16 * 10);
      rd(2'd3, "R3 count below large limit");
      wr(2'd0, cfg(1, 1, 2));
      idle(20);
      rd(2'd3, "R3 wrap after limit lowered");
      chk_irq("R3 irq after forced wrap", 1'b1);
      rd(2'd2, "R7 acknowledge after exceed test");

      // R6: clearing the run enable stops at the next zero
      wr(2'd0, cfg(0, 1, 7));
      idle(16 * 3 + 5);
      wr(2'd0, cfg(0, 0, 7));
      idle(30);
      rd(2'd3, "R6 still counting with enable clear");
      idle(100);
      rd(2'd3, "R6 halted at zero");
      idle(40);
      rd(2'd3, "R6 remains halted");
      rd(2'd2, "R7 acknowledge after stop test");

      // R3: largest limit reads back and counts
      wr(2'd0, cfg(0, 1, 20'hFFFFF));
      rd(2'd0, "R10 largest limit readback");
      idle(40);
      rd(2'd3, "R3 counting under largest limit");

      // R5: tally rollover with period of one step
      wr(2'd0, cfg(0, 1, 0));
      idle(16);
      rd(2'd2, "R7 acknowledge before rollover");
      idle(4094 * 16);
      rd(2'd3, "R5 tally just before rollover");
      idle(16 * 2);
      rd(2'd3, "R5 tally after rollover");

      idle(2);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule